// File: doc/BRIEF.md
# Paged Memory Mapper with Cartridge Banking

The block turns each 16-bit CPU byte address into a 21-bit physical address. The CPU space is cut into eight 8 KB windows. Each window has an 8-bit page register that picks one of 256 pages of 8 KB. The physical address is the selected page number joined to the low 13 address bits. The CPU loads the page registers by writing to a small block of byte addresses. That block sits in a different place in native mode than in compatibility mode. A register write is consumed by the mapper and never reaches memory.

In compatibility mode, window 3 (0x6000–0x7FFF) does not use its page register. It emulates a cartridge and always maps to page 0x36 or 0x37. A bank latch chooses between the two. Any write into the window loads the latch from byte-address bit 1, unless paging is switched off, in which case the window stays on page 0x36. Two write-enable bits gate memory writes into the lower and upper 4 KB halves of the window. The control bits sit in a 4-bit mode register with its own write strobe. The block has no data stream; the access pins and the control pins are plain, level-sampled signals, and there is no back-pressure.

Top module: `page_mapper`

## Requirements
- R1: After reset all page registers and the bank latch are 0 and the mode register is 0. This means compatibility mode, paging on, and both cartridge halves write-protected. So address 0x2345 maps to 0x000345, and 0x6010 maps to 0x06C010.
- R2: Outside the compatibility cartridge window, phys_addr = {page[cpu_addr[15:13]], cpu_addr[12:0]}. It is combinational from the stored page values.
- R3: In native mode a write to 0xF110+i (i = 0..7) loads page register i with cpu_wdata. The new value applies from the next cycle. mem_we stays 0 for that write.
- R4: In compatibility mode a write to 0x8000+i loads page register i, with mem_we 0. Writes to the register block of the other mode are ordinary memory writes and leave the page registers unchanged.
- R5: In compatibility mode a write to 0x8003 changes no register and is not forwarded (mem_we 0).
- R6: In compatibility mode, window 3 maps to page 0x36 when the bank latch is 0 and to page 0x37 when it is 1, whatever page register 3 holds.
- R7: While mode bit 1 (cartridge fixed) is 1, window 3 in compatibility mode maps to page 0x36, and writes into the window leave the bank latch unchanged.
- R8: With paging on, in compatibility mode, every write into 0x6000–0x7FFF loads the bank latch with cpu_addr[1]. The write itself uses the old bank. Reads leave the latch unchanged.
- R9: In compatibility mode, mem_we is 0 for writes to 0x6000–0x6FFF while mode bit 2 is 0, and for writes to 0x7000–0x7FFF while mode bit 3 is 0. The bank latch still loads on a suppressed write.
- R10: ctl_wr loads the mode register from ctl_data, effective the next cycle. The bits are: bit 0 = native mode, bit 1 = cartridge fixed, bit 2 = lower half writable, bit 3 = upper half writable.
- R11: In native mode window 3 uses page register 3, and writes there are never suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | Current access is a write |
| cpu_wdata | input | 8 | Write data, used by page-register writes |
| ctl_wr | input | 1 | Load mode register |
| ctl_data | input | 4 | New mode bits |
| phys_addr | output | 21 | Translated physical address |
| mem_we | output | 1 | Write qualifier toward memory |

## Verification
Several properties are checked on every cycle:
- register-port writes never raise mem_we;
- the cartridge window in compatibility mode only ever shows page 0x36 or 0x37, and only 0x36 when fixed;
- protected halves never raise mem_we;
- the bank latch follows address bit 1 only on qualifying writes;
- register 3 holds through compatibility writes to its address;
- the mode register only changes on its strobe.

The bench scenarios alone show the rest:
- the actual page values reached through both register ports;
- the one-cycle delay before a new page or bank applies;
- the mode-dependent aliasing of the two register blocks;
- a bank value surviving a period of fixed mapping.

// File: rtl/page_map_pkg.sv
package page_map_pkg;
  typedef struct packed {
    logic wr_en_hi;   // bit 3
    logic wr_en_lo;   // bit 2
    logic cart_fixed; // bit 1
    logic native;     // bit 0
  } map_ctl_t;
endpackage

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import page_map_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_wr,
  input  map_ctl_t ctl_d,
  output map_ctl_t ctl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_d;
  end

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_q)); // R10
endmodule

// File: rtl/pm_page_file.sv
module pm_page_file #(
  parameter int NUM_WIN = 8,
  parameter int PAGE_W  = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [PAGE_W-1:0]              wr_data,
  output logic [NUM_WIN-1:0][PAGE_W-1:0] pages
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                 pages[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))      pages[g] <= wr_data;
    end
  end

  AST_PAGES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pages)); // R2
endmodule

// File: rtl/pm_cart_bank.sv
module pm_cart_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel,
  output logic bank
);
  always_ff @(posedge clk) begin
    if (!rst_n)    bank <= 1'b0;
    else if (load) bank <= sel;
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bank == $past(sel))); // R8
  AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank)); // R8
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import page_map_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              PAGE_W     = 8,
  parameter int              NUM_WIN    = 8,
  parameter logic [15:0]     NAT_BASE   = 16'hF110,
  parameter logic [15:0]     CMP_BASE   = 16'h8000,
  parameter int              CART_WIN   = 3,
  parameter logic [7:0]      CART_PG_LO = 8'h36,
  parameter logic [7:0]      CART_PG_HI = 8'h37,
  parameter int              BANK_BIT   = 1,
  localparam int             WIN_BITS   = $clog2(NUM_WIN),
  localparam int             OFF_W      = ADDR_W - WIN_BITS,
  localparam int             PHYS_W     = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [PAGE_W-1:0] cpu_wdata,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_data,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              mem_we
);
  map_ctl_t                          ctl_q;
  logic [NUM_WIN-1:0][PAGE_W-1:0]    pages;
  logic                              bank;
  logic [WIN_BITS-1:0]               win, reg_idx;
  logic                              nat_hit, cmp_hit, reg_hit, in_cart;
  logic                              page_wr, cart_prot, bank_load;
  logic [PAGE_W-1:0]                 cart_page, sel_page;

  pm_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .ctl_d(map_ctl_t'(ctl_data)), .ctl_q(ctl_q)
  );

  assign win     = cpu_addr[ADDR_W-1 -: WIN_BITS];
  assign reg_idx = cpu_addr[WIN_BITS-1:0];
  assign nat_hit = cpu_addr[ADDR_W-1:WIN_BITS] == NAT_BASE[ADDR_W-1:WIN_BITS];
  assign cmp_hit = cpu_addr[ADDR_W-1:WIN_BITS] == CMP_BASE[ADDR_W-1:WIN_BITS];
  assign reg_hit = ctl_q.native ? nat_hit : cmp_hit;
  assign in_cart = !ctl_q.native && (win == WIN_BITS'(CART_WIN));
  assign page_wr = cpu_wr && reg_hit &&
                   (ctl_q.native || reg_idx != WIN_BITS'(CART_WIN));

  pm_page_file #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W)) u_pages (
    .clk(clk), .rst_n(rst_n), .wr_en(page_wr), .wr_idx(reg_idx),
    .wr_data(cpu_wdata), .pages(pages)
  );

  assign bank_load = cpu_wr && in_cart && !ctl_q.cart_fixed;

  pm_cart_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load),
    .sel(cpu_addr[BANK_BIT]), .bank(bank)
  );

  always_comb begin
    if (ctl_q.cart_fixed || !bank) cart_page = CART_PG_LO;
    else                           cart_page = CART_PG_HI;
    sel_page  = in_cart ? cart_page : pages[win];
    cart_prot = in_cart && (cpu_addr[OFF_W-1] ? !ctl_q.wr_en_hi : !ctl_q.wr_en_lo);
  end

  assign phys_addr = {sel_page, cpu_addr[OFF_W-1:0]};
  assign mem_we    = cpu_wr && !reg_hit && !cart_prot;

  AST_REG_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ctl_q.native && nat_hit) |-> !mem_we); // R3
  AST_CMP_REG_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ctl_q.native && cmp_hit) |-> !mem_we); // R4
  AST_REG3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ctl_q.native && cmp_hit && reg_idx == WIN_BITS'(CART_WIN))
    |=> $stable(pages[CART_WIN])); // R5
  AST_CART_PAGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.native && win == WIN_BITS'(CART_WIN)) |->
    (phys_addr[PHYS_W-1 -: PAGE_W] == CART_PG_LO ||
     phys_addr[PHYS_W-1 -: PAGE_W] == CART_PG_HI)); // R6
  AST_CART_FIXED_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.native && ctl_q.cart_fixed && win == WIN_BITS'(CART_WIN)) |->
    (phys_addr[PHYS_W-1 -: PAGE_W] == CART_PG_LO)); // R7
  AST_PROT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ctl_q.native && win == WIN_BITS'(CART_WIN) &&
     !cpu_addr[OFF_W-1] && !ctl_q.wr_en_lo) |-> !mem_we); // R9
  AST_PROT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ctl_q.native && win == WIN_BITS'(CART_WIN) &&
     cpu_addr[OFF_W-1] && !ctl_q.wr_en_hi) |-> !mem_we); // R9
endmodule

// File: tb/test_page_mapper.sv
module test_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [3:0]  ctl_data = '0;
  logic [20:0] phys_addr;
  logic        mem_we;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  page_mapper i_page_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .phys_addr(phys_addr), .mem_we(mem_we)
  );

  function automatic logic [20:0] xlat(input logic [7:0] pg, input logic [15:0] a);
    return {pg, a[12:0]};
  endfunction

  task automatic chk_addr(input logic [15:0] a, input logic [20:0] exp, input string tag);
    cpu_addr = a; cpu_wr = 1'b0;
    #1;
    n_vec++;
    if (phys_addr !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h phys actual=%h expected=%h", tag, a, phys_addr, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d,
                       input logic exp_we, input string tag);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    n_vec++;
    if (mem_we !== exp_we) begin
      n_bad++;
      $display("FAIL %s addr=%h mem_we actual=%b expected=%b", tag, a, mem_we, exp_we);
    end
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic set_ctl(input logic [3:0] d);
    ctl_data = d; ctl_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk_addr(16'h2345, 21'h000345, "R1 reset page");
    chk_addr(16'h6010, 21'h06C010, "R1 reset cart");
    do_wr(16'h6010, 8'h00, 1'b0, "R1 reset protect");
  endtask

  task automatic t_compat_regs;
    do_wr(16'h8000, 8'h12, 1'b0, "R4 reg0 write");
    do_wr(16'h8001, 8'h34, 1'b0, "R4 reg1 write");
    do_wr(16'h8007, 8'hFF, 1'b0, "R4 reg7 write");
    chk_addr(16'h0100, xlat(8'h12, 16'h0100), "R2 window0");
    chk_addr(16'h2000, xlat(8'h34, 16'h2000), "R2 window1");
    chk_addr(16'hE001, xlat(8'hFF, 16'hE001), "R2 window7");
    do_wr(16'h8003, 8'h55, 1'b0, "R5 reg3 write dropped");
    do_wr(16'hF110, 8'h99, 1'b1, "R4 native port is memory");
    chk_addr(16'h0100, xlat(8'h12, 16'h0100), "R4 reg0 kept");
  endtask

  task automatic t_native;
    set_ctl(4'b0001);
    chk_addr(16'h6000, xlat(8'h00, 16'h6000), "R5 reg3 unchanged");
    do_wr(16'h8004, 8'h77, 1'b1, "R4 compat port is memory");
    chk_addr(16'h8010, xlat(8'h00, 16'h8010), "R4 reg4 kept");
    do_wr(16'hF113, 8'hAB, 1'b0, "R3 reg3 write");
    chk_addr(16'h6004, 21'h156004, "R11 window3 uses reg");
    do_wr(16'h6000, 8'h00, 1'b1, "R11 no protect native");
    do_wr(16'hF110, 8'h01, 1'b0, "R3 reg0 write");
    chk_addr(16'h0000, 21'h002000, "R3 reg0 effective");
  endtask

  task automatic t_cart;
    set_ctl(4'b1100);
    chk_addr(16'h6000, 21'h06C000, "R6 bank0 ignores reg3");
    cpu_addr = 16'h6002; cpu_wdata = 8'h00; cpu_wr = 1'b1;
    #1;
    n_vec++;
    if (phys_addr !== 21'h06C002 || mem_we !== 1'b1) begin
      n_bad++;
      $display("FAIL R8 write old bank phys/we actual=%h/%b expected=%h/1",
               phys_addr, mem_we, 21'h06C002);
    end
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0;
    chk_addr(16'h7000, 21'h06F000, "R8 bank1 upper");
    @(posedge clk); @(negedge clk);
    chk_addr(16'h6000, 21'h06E000, "R8 read keeps bank");
    do_wr(16'h7FFC, 8'h00, 1'b1, "R8 write upper");
    chk_addr(16'h6100, 21'h06C100, "R8 bank back to 0");
  endtask

  task automatic t_protect;
    set_ctl(4'b0100);
    do_wr(16'h6000, 8'h00, 1'b1, "R9 lower writable");
    do_wr(16'h7002, 8'h00, 1'b0, "R9 upper protected");
    chk_addr(16'h6000, 21'h06E000, "R9 suppressed write latches");
    set_ctl(4'b1000);
    do_wr(16'h6000, 8'h00, 1'b0, "R9 lower protected");
    chk_addr(16'h6000, 21'h06C000, "R9 suppressed write latches lo");
    do_wr(16'h7000, 8'h00, 1'b1, "R9 upper writable");
  endtask

  task automatic t_fixed;
    set_ctl(4'b1100);
    do_wr(16'h6002, 8'h00, 1'b1, "R8 set bank1");
    set_ctl(4'b1110);
    chk_addr(16'h6000, 21'h06C000, "R7 fixed page");
    do_wr(16'h7FFC, 8'h00, 1'b1, "R7 write while fixed");
    chk_addr(16'h7000, 21'h06D000, "R7 still fixed");
    set_ctl(4'b1100);
    chk_addr(16'h6000, 21'h06E000, "R7 bank kept while fixed");
    chk_addr(16'hE001, xlat(8'hFF, 16'hE001), "R10 mode switch keeps pages");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_compat_regs();
    t_native();
    t_cart();
    t_protect();
    t_fixed();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule